// File: doc/BRIEF.md
# USB Host Interrupt Status Register with Line-State Detection

This block is the interrupt status byte of a USB host-side controller. Software reads one 8-bit status value and clears events by writing it back. Five sources can raise a latched flag:

- transfer done on register set A;
- transfer done on register set B;
- SOF timer expiry;
- cable insert or remove;
- resume detection.

A flag stays set until software writes a 1 to its bit position. Writing 0 to a bit leaves that flag as it is.

The block also watches the D+ and D- lines directly. It passes each line through a synchronizer and decodes the pair into SE0, IDLE or OTHER. A decoded state is accepted only after it has held for a set number of samples. An accepted change between SE0 and IDLE raises the insert/remove flag. Bit 7 shows the synchronized D+ level, which tells a low-speed device (0) from a full-speed one (1). Bit 6 depends on a mode pin: it is either a live "no device" indication or a latched resume flag.

A single active-high interrupt output combines the latched flags with an external enable mask. There is no streaming data path. Every pin is a plain control or status signal, and a write takes effect on the clock edge where `wr_en` is high.

Top module: `usb_irq_status`

## Requirements
- R1: After reset all latched flags are clear and `irq` is 0. With both lines low, `rd_data` reads 8'h40.
- R2: `rd_data[7]` equals the D+ input delayed by the two-stage synchronizer. It has no latching.
- R3: A write with `wr_en`=1 clears each latched flag whose `wr_data` bit is 1 and leaves every other flag unchanged.
- R4: When a set event and a write-one-to-clear hit the same flag in the same cycle, the flag ends up set.
- R5: A one-cycle pulse sets a flag. `done_a_evt` sets bit 0, `done_b_evt` sets bit 1 and `sof_evt` sets bit 4.
- R6: The synchronized line pair decodes as follows. SE0 is both lines low. IDLE is D+ high with D- low when `low_speed`=0, or D- high with D+ low when `low_speed`=1. Every other combination is OTHER. A decoded state becomes the accepted state only after STABLE_CYCLES consecutive samples, so a shorter run is ignored.
- R7: Bit 5 is set when the accepted state changes from SE0 to IDLE or from IDLE to SE0. Changes that involve OTHER do not set it.
- R8: With `resume_mode`=0, bit 6 reads 1 while the accepted state is SE0 (no device) and reads 0 otherwise.
- R9: With `resume_mode`=1, bit 6 reads a latched resume flag. `resume_evt` sets it and a write-one-to-clear clears it. A `resume_evt` that arrives while `resume_mode`=0 has no effect.
- R10: Bits 3 and 2 always read 0, and writing 1s to them changes nothing.
- R11: `irq` is the OR, over bits 5, 4, 1 and 0, of each latched flag ANDed with its `irq_mask` bit. Bit 6 joins that OR only when `resume_mode`=1. Bit 7 and the presence indication never raise `irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the status register |
| wr_data | input | 8 | Write data; a 1 clears the matching flag |
| rd_data | output | 8 | Current status byte |
| dp_in | input | 1 | D+ line level (asynchronous) |
| dm_in | input | 1 | D- line level (asynchronous) |
| low_speed | input | 1 | Selects which line marks IDLE: 0 = D+, 1 = D- |
| resume_mode | input | 1 | 1 = bit 6 is the resume flag; 0 = bit 6 is presence |
| resume_evt | input | 1 | Resume detected pulse |
| sof_evt | input | 1 | SOF timer expiry pulse |
| done_a_evt | input | 1 | Transfer done pulse, register set A |
| done_b_evt | input | 1 | Transfer done pulse, register set B |
| irq_mask | input | 8 | Interrupt enable mask |
| irq | output | 1 | Active-high interrupt request |

## Verification
The event flags are tried in three ways:
- isolated pulses, which show that each source maps to its own bit;
- clears that target only some bits, which separate clearing from holding;
- pulses that arrive together with a clear of the same bit, which expose which of set and clear has priority.

The line detector is driven with:
- a run one sample shorter than the stability window and a run exactly as long, to locate the acceptance threshold;
- true insertion and removal at both speeds, to show that the IDLE decoding follows the speed pin;
- a path through the K state, to show that only direct SE0↔IDLE changes count.

The resume and mask tests toggle the mode pin around resume pulses and offer presence as an interrupt source to separate live bits from latched ones. A long pseudo-random phase mixes every input against the reference model.

// File: rtl/usb_irq_pkg.sv
package usb_irq_pkg;
  typedef enum logic [1:0] {
    LS_SE0   = 2'd0,
    LS_IDLE  = 2'd1,
    LS_OTHER = 2'd2
  } line_st_e;

  localparam int BIT_DONE_A = 0;
  localparam int BIT_DONE_B = 1;
  localparam int BIT_SOF    = 4;
  localparam int BIT_INSREM = 5;
  localparam int BIT_DETRES = 6;
  localparam int BIT_DPLUS  = 7;

  localparam logic [7:0] LATCH_BITS = 8'b0111_0011;
endpackage

// File: rtl/usb_line_sync.sv
module usb_line_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
    end else begin
      stg[0] <= din;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign dout = stg[STAGES-1];
endmodule

// File: rtl/usb_line_filter.sv
module usb_line_filter
  import usb_irq_pkg::*;
#(
  parameter int STABLE_CYCLES = 4
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     dp,
  input  logic     dm,
  input  logic     low_speed,
  output line_st_e acc_state,
  output logic     ins_rem_evt
);
  localparam int CW = $clog2(STABLE_CYCLES + 1);
  localparam logic [CW-1:0] RUN_MAX = CW'(STABLE_CYCLES);

  line_st_e dec;
  line_st_e cand;
  line_st_e acc;
  logic [CW-1:0] run;
  logic accept;
  logic idle_now;

  always_comb begin
    idle_now = low_speed ? (dm && !dp) : (dp && !dm);
    if (!dp && !dm)    dec = LS_SE0;
    else if (idle_now) dec = LS_IDLE;
    else               dec = LS_OTHER;
  end

  assign accept      = (run == RUN_MAX) && (cand != acc);
  assign ins_rem_evt = accept &&
                       (((acc == LS_SE0) && (cand == LS_IDLE)) ||
                        ((acc == LS_IDLE) && (cand == LS_SE0)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cand <= LS_SE0;
      acc  <= LS_SE0;
      run  <= '0;
    end else begin
      if (accept) acc <= cand;
      if (dec != cand) begin
        cand <= dec;
        run  <= CW'(1);
      end else if (run != RUN_MAX) begin
        run <= run + CW'(1);
      end
    end
  end

  assign acc_state = acc;

  AST_ACC_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    (run != RUN_MAX) |=> $stable(acc)); // R6
  AST_EVT_CHANGES_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    ins_rem_evt |=> (acc != $past(acc))); // R7
  AST_EVT_ENDPOINTS: assert property (@(posedge clk) disable iff (!rst_n)
    ins_rem_evt |=> ((acc == LS_SE0) || (acc == LS_IDLE))); // R7
endmodule

// File: rtl/usb_irq_flags.sv
module usb_irq_flags #(
  parameter int         WIDTH = 8,
  parameter logic [7:0] LATCH = 8'b0111_0011
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] set,
  input  logic [WIDTH-1:0] clr,
  output logic [WIDTH-1:0] flags
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    if (LATCH[i]) begin : g_latched
      logic q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= 1'b0;
        else        q <= (q && !clr[i]) || set[i];
      end
      assign flags[i] = q;

      AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        set[i] |=> flags[i]); // R4
      AST_W1C: assert property (@(posedge clk) disable iff (!rst_n)
        (clr[i] && !set[i]) |=> !flags[i]); // R3
      AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr[i] && !set[i]) |=> $stable(flags[i])); // R3
    end else begin : g_plain
      logic unused_in;
      assign unused_in = set[i] ^ clr[i];
      assign flags[i]  = 1'b0;
    end
  end
endmodule

// File: rtl/usb_irq_status.sv
module usb_irq_status
  import usb_irq_pkg::*;
#(
  parameter int STABLE_CYCLES = 4,
  parameter int SYNC_STAGES   = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  output logic [7:0] rd_data,
  input  logic       dp_in,
  input  logic       dm_in,
  input  logic       low_speed,
  input  logic       resume_mode,
  input  logic       resume_evt,
  input  logic       sof_evt,
  input  logic       done_a_evt,
  input  logic       done_b_evt,
  input  logic [7:0] irq_mask,
  output logic       irq
);
  logic [1:0] line_s;
  logic       dp_s;
  logic       dm_s;
  line_st_e   line_state;
  logic       ins_rem_evt;
  logic [7:0] set_vec;
  logic [7:0] clr_vec;
  logic [7:0] flags;
  logic [7:0] irq_src;
  logic       unused_top;

  usb_line_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  ({dp_in, dm_in}),
    .dout (line_s)
  );
  assign dp_s = line_s[1];
  assign dm_s = line_s[0];

  usb_line_filter #(.STABLE_CYCLES(STABLE_CYCLES)) u_filter (
    .clk        (clk),
    .rst_n      (rst_n),
    .dp         (dp_s),
    .dm         (dm_s),
    .low_speed  (low_speed),
    .acc_state  (line_state),
    .ins_rem_evt(ins_rem_evt)
  );

  always_comb begin
    set_vec             = '0;
    set_vec[BIT_DONE_A] = done_a_evt;
    set_vec[BIT_DONE_B] = done_b_evt;
    set_vec[BIT_SOF]    = sof_evt;
    set_vec[BIT_INSREM] = ins_rem_evt;
    set_vec[BIT_DETRES] = resume_evt && resume_mode;
  end

  assign clr_vec = wr_en ? wr_data : 8'h00;

  usb_irq_flags #(.WIDTH(8), .LATCH(LATCH_BITS)) u_flags (
    .clk  (clk),
    .rst_n(rst_n),
    .set  (set_vec),
    .clr  (clr_vec),
    .flags(flags)
  );

  assign unused_top = ^{flags[7], flags[3:2]};

  always_comb begin
    rd_data             = flags & LATCH_BITS;
    rd_data[BIT_DPLUS]  = dp_s;
    rd_data[BIT_DETRES] = resume_mode ? flags[BIT_DETRES] : (line_state == LS_SE0);
  end

  always_comb begin
    irq_src             = flags & LATCH_BITS;
    irq_src[BIT_DETRES] = flags[BIT_DETRES] && resume_mode;
  end

  assign irq = |(irq_src & irq_mask);

  AST_IRQ_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ((|(rd_data[5:0] & irq_mask[5:0])) ||
             (resume_mode && rd_data[6] && irq_mask[6]))); // R11
  AST_INSREM_LATCHES: assert property (@(posedge clk) disable iff (!rst_n)
    ins_rem_evt |=> rd_data[5]); // R7
endmodule

// File: tb/usb_irq_status_tb.sv
`timescale 1ns/1ps
module usb_irq_status_tb;
  localparam int STB = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic dp_in = 1'b0, dm_in = 1'b0;
  logic low_speed = 1'b0, resume_mode = 1'b0, resume_evt = 1'b0;
  logic sof_evt = 1'b0, done_a_evt = 1'b0, done_b_evt = 1'b0;
  logic [7:0] irq_mask = 8'h00;
  logic irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  usb_irq_status #(.STABLE_CYCLES(STB), .SYNC_STAGES(2)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .dp_in(dp_in), .dm_in(dm_in), .low_speed(low_speed),
    .resume_mode(resume_mode), .resume_evt(resume_evt), .sof_evt(sof_evt),
    .done_a_evt(done_a_evt), .done_b_evt(done_b_evt), .irq_mask(irq_mask),
    .irq(irq)
  );

  // Reference model: line states 0 = SE0, 1 = IDLE, 2 = OTHER
  logic m_dp1 = 0, m_dp2 = 0, m_dm1 = 0, m_dm2 = 0;
  int   m_cand = 0, m_run = 0, m_acc = 0;
  logic [7:0] mf = 8'h00;

  always @(posedge clk) begin
    int dec;
    bit ev;
    logic [7:0] setv, clr;
    if (!rst_n) begin
      m_dp1 = 0; m_dp2 = 0; m_dm1 = 0; m_dm2 = 0;
      m_cand = 0; m_run = 0; m_acc = 0; mf = 8'h00;
    end else begin
      if (!m_dp2 && !m_dm2) dec = 0;
      else if (low_speed ? (m_dm2 && !m_dp2) : (m_dp2 && !m_dm2)) dec = 1;
      else dec = 2;
      ev = 0;
      if (m_run == STB && m_cand != m_acc) begin
        ev = (m_acc == 0 && m_cand == 1) || (m_acc == 1 && m_cand == 0);
        m_acc = m_cand;
      end
      if (dec != m_cand) begin m_cand = dec; m_run = 1; end
      else if (m_run != STB) m_run = m_run + 1;
      clr  = wr_en ? wr_data : 8'h00;
      setv = {1'b0, resume_evt && resume_mode, ev, sof_evt, 2'b00, done_b_evt, done_a_evt};
      mf   = ((mf & ~clr) | setv) & 8'h73;
      m_dp2 = m_dp1; m_dp1 = dp_in;
      m_dm2 = m_dm1; m_dm1 = dm_in;
    end
  end

  task automatic check(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    logic [7:0] er;
    logic ei;
    if (rst_n && !done) begin
      er = {m_dp2, resume_mode ? mf[6] : (m_acc == 0), mf[5:0]};
      ei = |({1'b0, resume_mode & mf[6], mf[5:0]} & irq_mask);
      check(rd_data[7] == er[7], "R2 dplus bit", rd_data, er);
      check(rd_data[6] == er[6], resume_mode ? "R9 resume bit" : "R8 presence bit", rd_data, er);
      check(rd_data[5] == er[5], "R7 insert/remove bit", rd_data, er);
      check({rd_data[4], rd_data[1:0]} == {er[4], er[1:0]}, "R5 event bits", rd_data, er);
      check(rd_data[3:2] == 2'b00, "R10 reserved bits", rd_data, er);
      check(irq == ei, "R11 irq", {7'd0, irq}, {7'd0, ei});
    end
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [7:0] d);
    wr_en = 1'b1; wr_data = d;
    step(1);
    wr_en = 1'b0; wr_data = 8'h00;
  endtask

  task automatic expect_rd(input logic [7:0] e, input string tag);
    @(negedge clk);
    check(rd_data == e, tag, rd_data, e);
    #1;
  endtask

  task automatic expect_irq(input logic e, input string tag);
    @(negedge clk);
    check(irq == e, tag, {7'd0, irq}, {7'd0, e});
    #1;
  endtask

  initial begin
    logic [15:0] lfsr;
    step(3);
    rst_n = 1'b1;
    expect_rd(8'h40, "R1 reset status");
    expect_irq(1'b0, "R1 reset irq");

    done_a_evt = 1; done_b_evt = 1; sof_evt = 1;
    step(1);
    done_a_evt = 0; done_b_evt = 0; sof_evt = 0;
    expect_rd(8'h53, "R5 pulses latch");
    wr(8'h01);
    expect_rd(8'h52, "R3 partial clear");
    done_b_evt = 1; wr(8'h02); done_b_evt = 0;
    expect_rd(8'h52, "R4 set beats clear");
    wr(8'hFF);
    expect_rd(8'h40, "R3 clear all");
    wr(8'h0C);
    expect_rd(8'h40, "R10 reserved write");

    dp_in = 1; step(STB - 1); dp_in = 0; step(12);
    expect_rd(8'h40, "R6 short run ignored");
    dp_in = 1; step(STB); dp_in = 0; step(12);
    expect_rd(8'h60, "R6 full run accepted");
    wr(8'h20);

    dp_in = 1; step(12);
    expect_rd(8'hA0, "R7 full-speed insert");
    wr(8'h20);
    expect_rd(8'h80, "R8 present reads 0");
    dp_in = 0; step(12);
    expect_rd(8'h60, "R7 removal");
    wr(8'h20);

    dm_in = 1; step(12);
    expect_rd(8'h00, "R7 SE0 to K no flag");
    dp_in = 1; dm_in = 0; step(12);
    expect_rd(8'h80, "R7 K to IDLE no flag");
    dp_in = 0; step(12);
    expect_rd(8'h60, "R7 IDLE to SE0");
    wr(8'h20);

    low_speed = 1; dm_in = 1; step(12);
    expect_rd(8'h20, "R7 low-speed insert");
    dm_in = 0; step(12); wr(8'h20);
    low_speed = 0;
    expect_rd(8'h40, "R8 absent reads 1");

    resume_mode = 1;
    expect_rd(8'h00, "R9 resume flag clear");
    resume_evt = 1; step(1); resume_evt = 0;
    expect_rd(8'h40, "R9 resume latched");
    irq_mask = 8'h40;
    expect_irq(1'b1, "R11 resume irq");
    wr(8'h40);
    expect_rd(8'h00, "R9 resume cleared");
    resume_mode = 0; resume_evt = 1; step(1); resume_evt = 0;
    resume_mode = 1;
    expect_rd(8'h00, "R9 resume ignored in presence mode");
    resume_mode = 0;
    expect_irq(1'b0, "R11 presence never irq");

    done_a_evt = 1; step(1); done_a_evt = 0;
    irq_mask = 8'h00;
    expect_irq(1'b0, "R11 masked");
    irq_mask = 8'h01;
    expect_irq(1'b1, "R11 enabled");
    wr(8'h01);
    irq_mask = 8'hFF;
    expect_irq(1'b0, "R11 dplus and presence excluded");

    lfsr = 16'hACE1;
    for (int i = 0; i < 3000; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      done_a_evt  = (lfsr[2:0] == 3'd1);
      done_b_evt  = (lfsr[3:1] == 3'd2);
      sof_evt     = (lfsr[5:3] == 3'd3);
      resume_evt  = (lfsr[6:4] == 3'd4);
      wr_en       = (lfsr[9:8] == 2'd0);
      wr_data     = lfsr[15:8];
      irq_mask    = lfsr[7:0] ^ lfsr[15:8];
      if (lfsr[12:10] == 3'd5) resume_mode = ~resume_mode;
      if (lfsr[15:11] == 5'd7) low_speed = ~low_speed;
      if (lfsr[14:12] == 3'd6) begin dp_in = lfsr[0]; dm_in = lfsr[1]; end
      step(1);
    end
    {done_a_evt, done_b_evt, sof_evt, resume_evt, wr_en} = '0;
    step(4);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL R1 watchdog actual 0 expected 1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule